// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block holds the page-mapping table of a processor whose translation entries are loaded by software. It is a fully associative array of a power-of-two number of slots. Each slot maps an even/odd pair of adjacent virtual pages. A slot stores a virtual page number, an 8-bit address-space identifier (ASID), a global flag, a page-size mask and two physical frame descriptors. Each descriptor carries a frame number, a valid flag, a dirty flag and a 3-bit cache attribute.

Software drives four commands through one command port: write a slot chosen by an index word, write a slot chosen by a random value, read a slot back into register-format words, and probe the table for a virtual tag. Every command is taken in the cycle `cmd_valid_i` is high. Its results are registered and appear, together with a one-cycle `done_o`, in the following cycle. A probe reports a hit as the lowest matching slot number and a miss through bit 31 of the slot word. A read that would change the live ASID to that of a non-global slot raises a one-cycle flush request.

Top module: `tlb_mgr`

## Requirements
- R1: After reset, `done_o`, `asid_flush_o` and all word outputs are zero. Every slot is cleared, so a read of any slot returns zero words, and both valid flags (word bit 1) are zero.
- R2: A write with `cmd_i`=2 (indexed) stores into slot `slot_i` mod N. The stored VPN is `tag_i[31:13]`, the ASID is `tag_i[7:0]` and the size field is `size_mask_i[24:13]`. Bits 12:8 of `tag_i` are dropped.
- R3: The stored global flag is `pte_even_i[0]` AND `pte_odd_i[0]`. On read it appears in bit 0 of both descriptor words.
- R4: For each descriptor word, bit 1 is the valid flag, bit 2 the dirty flag, bits 5:3 the cache attribute and bits 29:6 the frame number. On read the word is rebuilt from these fields, with bits 31:30 reading zero.
- R5: A write with `cmd_i`=3 (random) stores into slot `rand_slot_i`, and `slot_i` has no effect on it.
- R6: A probe (`cmd_i`=0) matches a slot when the slot is global or its ASID equals `tag_i[7:0]`, and its VPN equals `tag_i[31:13]`. Valid flags are not consulted. On a hit `slot_o` becomes the lowest matching slot number, with all other bits zero.
- R7: On a probe miss `slot_o` becomes `slot_i` with bit 31 forced to 1, and bits 30:0 are copied unchanged.
- R8: A read (`cmd_i`=1) of slot `slot_i` mod N sets `tag_o` = {VPN, 5'b0, ASID} and `size_mask_o` = size field << 13. It also sets `pte_even_o` and `pte_odd_o` as in R3 and R4.
- R9: `asid_flush_o` is high for exactly the cycle after a read whose slot is not global and whose stored ASID differs from `tag_i[7:0]`. Otherwise it is low.
- R10: `done_o` is high in the cycle after each accepted command and low otherwise. `slot_o` changes only after a probe, and the read outputs change only after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | 0 probe, 1 read, 2 indexed write, 3 random write |
| tag_i | input | 32 | Virtual tag word: VPN in 31:13, ASID in 7:0 |
| pte_even_i | input | 32 | Even-page descriptor word |
| pte_odd_i | input | 32 | Odd-page descriptor word |
| size_mask_i | input | 32 | Page-size mask, field in 24:13 |
| slot_i | input | 32 | Slot word used by read, indexed write and probe miss |
| rand_slot_i | input | log2(N) | Slot for random write |
| done_o | output | 1 | Command completed (one cycle) |
| slot_o | output | 32 | Probe result |
| tag_o | output | 32 | Tag word rebuilt by read |
| pte_even_o | output | 32 | Even descriptor rebuilt by read |
| pte_odd_o | output | 32 | Odd descriptor rebuilt by read |
| size_mask_o | output | 32 | Size mask rebuilt by read |
| asid_flush_o | output | 1 | ASID change flush request |

## Verification
The assertions assume that `cmd_i` and every data input hold known values whenever `cmd_valid_i` is high. They also assume that commands may follow each other with no gap and still complete in one cycle. The bench drives all inputs on the falling edge, from fully defined patterns, and holds them through the sampling edge. It sweeps every slot with address bits above log2(N) set, so the modulo indexing is exercised. Duplicate-tag probes are built on purpose, because the assertions on the priority encoder can only confirm the lowest-match rule when two slots share a tag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VPN_W   = 19;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned PMASK_W = 12;
  localparam int unsigned PFN_W   = 24;
  localparam int unsigned CATTR_W = 3;

  typedef enum logic [1:0] {
    CMD_PROBE  = 2'd0,
    CMD_READ   = 2'd1,
    CMD_WR_IDX = 2'd2,
    CMD_WR_RND = 2'd3
  } tlb_cmd_e;

  typedef struct packed {
    logic               v;
    logic               d;
    logic [CATTR_W-1:0] c;
    logic [PFN_W-1:0]   pfn;
  } tlb_half_t;

  typedef struct packed {
    logic [VPN_W-1:0]   vpn;
    logic [ASID_W-1:0]  asid;
    logic               g;
    logic [PMASK_W-1:0] pmask;
    tlb_half_t          even;
    tlb_half_t          odd;
  } tlb_entry_t;

  // descriptor word bits 29:1 -> fields
  function automatic tlb_half_t pte_decode(input logic [29:1] w);
    tlb_half_t h;
    h.v   = w[1];
    h.d   = w[2];
    h.c   = w[5:3];
    h.pfn = w[29:6];
    return h;
  endfunction

  function automatic logic [31:0] pte_encode(input tlb_half_t h, input logic g);
    return {2'b00, h.pfn, h.c, h.d, h.v, g};
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDXW = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDXW-1:0]   waddr_i,
  input  tlb_entry_t        wdata_i,
  input  logic [IDXW-1:0]   raddr_i,
  output tlb_entry_t        rdata_o,
  output logic [VPN_W-1:0]  vpn_o  [N_ENTRIES],
  output logic [ASID_W-1:0] asid_o [N_ENTRIES],
  output logic              g_o    [N_ENTRIES]
);
  tlb_entry_t ent_q [N_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(N_ENTRIES); e++) ent_q[e] <= '0;
    end else if (we_i) begin
      ent_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_tag
    assign vpn_o[e]  = ent_q[e].vpn;
    assign asid_o[e] = ent_q[e].asid;
    assign g_o[e]    = ent_q[e].g;
  end

  assign rdata_o = ent_q[raddr_i];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ent_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/tlb_probe_match.sv
module tlb_probe_match
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDXW = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]  vpn_tab_i  [N_ENTRIES],
  input  logic [ASID_W-1:0] asid_tab_i [N_ENTRIES],
  input  logic              g_tab_i    [N_ENTRIES],
  output logic              hit_o,
  output logic [IDXW-1:0]   hit_idx_o
);
  logic [N_ENTRIES-1:0] match_vec;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = (g_tab_i[e] || (asid_tab_i[e] == asid_i)) &&
                          (vpn_tab_i[e] == vpn_i);
  end

  // walk downward so the lowest match wins
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int e = int'(N_ENTRIES) - 1; e >= 0; e--) begin
      if (match_vec[e]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDXW'(e);
      end
    end
  end

  p_hit_is_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_vec[hit_idx_o]);
  p_no_lower_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_vec & ((N_ENTRIES'(1) << hit_idx_o) - N_ENTRIES'(1))) == '0));
  p_miss_means_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (match_vec == '0));
endmodule

// File: rtl/tlb_mgr.sv
module tlb_mgr
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDXW = $clog2(N_ENTRIES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_i,
  input  logic [31:0]     tag_i,
  input  logic [31:0]     pte_even_i,
  input  logic [31:0]     pte_odd_i,
  input  logic [31:0]     size_mask_i,
  input  logic [31:0]     slot_i,
  input  logic [IDXW-1:0] rand_slot_i,
  output logic            done_o,
  output logic [31:0]     slot_o,
  output logic [31:0]     tag_o,
  output logic [31:0]     pte_even_o,
  output logic [31:0]     pte_odd_o,
  output logic [31:0]     size_mask_o,
  output logic            asid_flush_o
);
  localparam logic [31:0] MISS_BIT = 32'h8000_0000;

  tlb_cmd_e          cmd;
  logic              is_probe, is_read, we;
  logic [IDXW-1:0]   waddr, raddr;
  tlb_entry_t        wdata, rdata;
  logic [VPN_W-1:0]  vpn_tab  [N_ENTRIES];
  logic [ASID_W-1:0] asid_tab [N_ENTRIES];
  logic              g_tab    [N_ENTRIES];
  logic              hit;
  logic [IDXW-1:0]   hit_idx;
  logic              unused_bits;

  logic        done_q, flush_q;
  logic [31:0] slot_q, tag_q, even_q, odd_q, mask_q;

  assign cmd      = tlb_cmd_e'(cmd_i);
  assign is_probe = cmd_valid_i && (cmd == CMD_PROBE);
  assign is_read  = cmd_valid_i && (cmd == CMD_READ);
  assign we       = cmd_valid_i && ((cmd == CMD_WR_IDX) || (cmd == CMD_WR_RND));
  assign waddr    = (cmd == CMD_WR_RND) ? rand_slot_i : slot_i[IDXW-1:0];
  assign raddr    = slot_i[IDXW-1:0];

  assign unused_bits = ^{tag_i[12:8], size_mask_i[31:25], size_mask_i[12:0],
                         pte_even_i[31:30], pte_odd_i[31:30]};

  always_comb begin
    wdata       = '0;
    wdata.vpn   = tag_i[31:13];
    wdata.asid  = tag_i[7:0];
    wdata.g     = pte_even_i[0] & pte_odd_i[0];
    wdata.pmask = size_mask_i[24:13];
    wdata.even  = pte_decode(pte_even_i[29:1]);
    wdata.odd   = pte_decode(pte_odd_i[29:1]);
  end

  tlb_entry_array #(.N_ENTRIES(N_ENTRIES)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata),
    .vpn_o   (vpn_tab),
    .asid_o  (asid_tab),
    .g_o     (g_tab)
  );

  tlb_probe_match #(.N_ENTRIES(N_ENTRIES)) u_probe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vpn_i      (tag_i[31:13]),
    .asid_i     (tag_i[7:0]),
    .vpn_tab_i  (vpn_tab),
    .asid_tab_i (asid_tab),
    .g_tab_i    (g_tab),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      slot_q  <= '0;
      tag_q   <= '0;
      even_q  <= '0;
      odd_q   <= '0;
      mask_q  <= '0;
    end else begin
      done_q  <= cmd_valid_i;
      flush_q <= is_read && !rdata.g && (rdata.asid != tag_i[7:0]);
      if (is_probe) begin
        slot_q <= hit ? {{(32-IDXW){1'b0}}, hit_idx} : (slot_i | MISS_BIT);
      end
      if (is_read) begin
        tag_q  <= {rdata.vpn, 5'b00000, rdata.asid};
        mask_q <= {7'd0, rdata.pmask, 13'd0};
        even_q <= pte_encode(rdata.even, rdata.g);
        odd_q  <= pte_encode(rdata.odd, rdata.g);
      end
    end
  end

  assign done_o       = done_q;
  assign asid_flush_o = flush_q;
  assign slot_o       = slot_q;
  assign tag_o        = tag_q;
  assign pte_even_o   = even_q;
  assign pte_odd_o    = odd_q;
  assign size_mask_o  = mask_q;

  p_done_follows_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);
  p_slot_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_probe |=> $stable(slot_o));
  p_read_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_read |=> ($stable(tag_o) && $stable(pte_even_o) && $stable(pte_odd_o)));
  p_miss_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_probe && !hit) |=> (slot_o == ($past(slot_i) | MISS_BIT)));
  p_hit_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_probe && hit) |=> !slot_o[31]);
  p_flush_only_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asid_flush_o |-> $past(is_read));
  p_flush_global_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asid_flush_o |-> !pte_even_o[0]);
  p_hi_bits_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pte_even_o[31:30] == 2'b00) && (pte_odd_o[31:30] == 2'b00));
endmodule

// File: tb/tlb_mgr_tb.sv
module tlb_mgr_tb;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = '0;
  logic [31:0] tag = '0, pe = '0, po = '0, pm = '0, slot = '0;
  logic [IW-1:0] rslot = '0;
  logic done, flush;
  logic [31:0] slot_o, tag_o, pe_o, po_o, pm_o;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tlb_mgr #(.N_ENTRIES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .tag_i(tag), .pte_even_i(pe), .pte_odd_i(po), .size_mask_i(pm),
    .slot_i(slot), .rand_slot_i(rslot), .done_o(done), .slot_o(slot_o),
    .tag_o(tag_o), .pte_even_o(pe_o), .pte_odd_o(po_o), .size_mask_o(pm_o),
    .asid_flush_o(flush)
  );

  function automatic logic [18:0] f_vpn(int i); return 19'(32'h4000 + i * 1237); endfunction
  function automatic logic [7:0]  f_asid(int i); return 8'(i * 5 + 2); endfunction
  function automatic logic [31:0] f_tag(int i); return {f_vpn(i), 5'b10101, f_asid(i)}; endfunction
  function automatic logic g0(int i); return (i % 4 == 0) || (i % 4 == 1); endfunction
  function automatic logic g1(int i); return (i % 4 == 0) || (i % 4 == 2); endfunction
  function automatic logic [31:0] f_pe(int i);
    return {2'b10, 24'(i * 32'h1357 + 32'h111), 3'(i), i[0], 1'b1, g0(i)};
  endfunction
  function automatic logic [31:0] f_po(int i);
    return {2'b01, 24'(i * 32'hABC + 32'h222), 3'(7 - i), ~i[0], i[1], g1(i)};
  endfunction
  function automatic logic [31:0] f_pm(int i); return 32'hFE00_1FFF | (32'(12'(i * 273)) << 13); endfunction
  function automatic logic [31:0] x_tag(int i); return {f_vpn(i), 5'b0, f_asid(i)}; endfunction
  function automatic logic [31:0] x_pe(int i); return (f_pe(i) & 32'h3FFF_FFFE) | 32'(g0(i) & g1(i)); endfunction
  function automatic logic [31:0] x_po(int i); return (f_po(i) & 32'h3FFF_FFFE) | 32'(g0(i) & g1(i)); endfunction
  function automatic logic [31:0] x_pm(int i); return f_pm(i) & 32'h01FF_E000; endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [31:0] t, input logic [31:0] e,
                       input logic [31:0] o, input logic [31:0] m, input logic [31:0] s,
                       input logic [IW-1:0] r);
    @(negedge clk);
    cmd = c; tag = t; pe = e; po = o; pm = m; slot = s; rslot = r;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(32'(done), 32'd1, "R10 done after command");
  endtask

  task automatic rd_check(input int s, input int i, input string req);
    issue(2'd1, x_tag(i), 32'h0, 32'h0, 32'h0, 32'(s), '0);
    chk(tag_o, x_tag(i), {req, " tag"});
    chk(pe_o, x_pe(i), {req, " even"});
    chk(po_o, x_po(i), {req, " odd"});
    chk(pm_o, x_pm(i), {req, " mask"});
    chk(32'(flush), 32'd0, "R9 same asid no flush");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(32'(done), 0, "R1 done");
    chk(32'(flush), 0, "R1 flush");
    chk(slot_o, 0, "R1 slot");
    chk(tag_o | pe_o | po_o | pm_o, 0, "R1 read outputs");
    for (int i = 0; i < N; i++) begin
      issue(2'd1, 32'h0, 0, 0, 0, 32'(i), '0);
      chk({30'd0, pe_o[1], po_o[1]}, 0, "R1 valid cleared");
      chk(pe_o | po_o | tag_o, 0, "R1 slot zero");
    end
    @(negedge clk);
    chk(32'(done), 0, "R10 done idle");

    // R2 R3 R4 indexed writes with high slot bits set
    for (int i = 0; i < N; i++)
      issue(2'd2, f_tag(i), f_pe(i), f_po(i), f_pm(i), 32'(i) | 32'h0000_0130, '0);
    chk(slot_o, 0, "R10 slot untouched by writes");
    for (int i = 0; i < N; i++) rd_check(i + 16 * 7, i, "R8 R2 R3 R4 readback");

    // R6 probe hits
    for (int i = 0; i < N; i++) begin
      issue(2'd0, f_tag(i), 0, 0, 0, 32'h0000_0055, '0);
      chk(slot_o, 32'(i), "R6 probe hit");
    end
    issue(2'd0, {f_vpn(4), 5'b0, 8'hEE}, 0, 0, 0, 32'h0, '0);
    chk(slot_o, 32'd4, "R6 global ignores asid");

    // R7 misses
    issue(2'd0, {19'h7FFFF, 5'b0, 8'h01}, 0, 0, 0, 32'h0000_1234, '0);
    chk(slot_o, 32'h8000_1234, "R7 miss absent vpn");
    issue(2'd0, {f_vpn(1), 5'b0, f_asid(1) + 8'd1}, 0, 0, 0, 32'h7FFF_FFF0, '0);
    chk(slot_o, 32'hFFFF_FFF0, "R7 miss wrong asid");
    issue(2'd0, {f_vpn(3), 5'b0, f_asid(3) ^ 8'h80}, 0, 0, 0, 32'h8000_0003, '0);
    chk(slot_o, 32'h8000_0003, "R7 miss bit already set");

    // R9 flush
    issue(2'd1, {19'd0, 5'd0, f_asid(1) + 8'd1}, 0, 0, 0, 32'd1, '0);
    chk(32'(flush), 1, "R9 flush on asid change");
    chk(tag_o, x_tag(1), "R8 tag during flush");
    @(negedge clk);
    chk(32'(flush), 0, "R9 flush one cycle");
    chk(32'(done), 0, "R10 done one cycle");
    issue(2'd1, {19'd0, 5'd0, 8'hEE}, 0, 0, 0, 32'd8, '0);
    chk(32'(flush), 0, "R9 no flush for global");

    // R5 random write, slot_i ignored
    issue(2'd3, f_tag(20), f_pe(20), f_po(20), f_pm(20), 32'd2, 4'd13);
    rd_check(13, 20, "R5 random target");
    rd_check(2, 2, "R5 slot_i untouched");
    // R6 lowest of duplicates
    issue(2'd0, f_tag(20), 0, 0, 0, 0, '0);
    chk(slot_o, 32'd13, "R6 single copy");
    issue(2'd2, f_tag(20), f_pe(20), f_po(20), f_pm(20), 32'd6, 4'd0);
    issue(2'd0, f_tag(20), 0, 0, 0, 0, '0);
    chk(slot_o, 32'd6, "R6 lowest duplicate");
    rd_check(0, 0, "R5 rand_slot ignored on indexed write");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule